// File: doc/BRIEF.md
# Programmable Parallel Port Controller

This block gives a host three 8-bit parallel ports behind four byte registers. A host access is qualified by an active-low select together with active-low read or write strobes. All host and pin inputs are sampled on the block clock. Every clock in which a strobe is active is one access, so a host must hold each strobe for a single cycle. Read data is driven combinationally while a read is active. A read's side effects, such as clearing a buffer-full flag, take effect at the clock edge that ends that cycle.

The ports are organised as two groups. Group A is port A together with port C bits 7..4. Group B is port B together with port C bits 3..0. Each group is programmed either as plain I/O or as strobed I/O.

- In plain I/O, an output port drives its write latch and an input port reads its pins live.
- In strobed I/O, port C pins are taken over as handshake lines. For input these are a strobe, a buffer-full flag and an interrupt request. For output they are an active-low buffer-full flag, an acknowledge and an interrupt request. The interrupt enables are held in port C latch bits that the host sets through single-bit commands.

Every pin has its own output-enable, so the block can sit in front of tristate pads.

Top module: `par_port_ctrl`

## Requirements
- R1: addr_i selects 0 = port A, 1 = port B, 2 = port C, 3 = control. Writes and reads take effect only while cs_ni is low. rdata_o is 0 when no read is active. A read of address 3 returns 0.
- R2: After reset every port is an input in plain mode, all output-enables are 0, and port reads return the pins.
- R3: A control write with bit 7 = 1 is a mode word. Its fields are: bits 6:5 group A mode (00 plain), bit 4 port A direction, bit 3 port C upper direction, bit 2 group B mode (0 plain), bit 1 port B direction, bit 0 port C lower direction. A direction bit of 1 means input, and an output-enable is high only for output pins.
- R4: A control write with bit 7 = 0 loads bit 0 into the port C latch bit indexed by bits 3:1. No other port C latch bit changes.
- R5: A mode word clears the output latches of ports A, B and C and all handshake state. The output buffer-full flags are left inactive (high).
- R6: In plain mode, an output port drives and reads back its last written value, and an input port reads its pins.
- R7: In group A strobed input, a low level on PC4 latches the port A pins and raises input-buffer-full on PC5. In group B strobed input, PC2 and PC1 play the same roles. A port read returns the latched byte even after the pins change.
- R8: In strobed input, the interrupt request rises when the strobe returns high, but only if the enable latch bit is 1. For group A the request is on PC3 and the enable is PC4. For group B the request is on PC0 and the enable is PC2.
- R9: A host read of a strobed input port clears its input-buffer-full and interrupt request.
- R10: In strobed output, a host write to the port drives the active-low buffer-full flag low and clears the interrupt request. For group A the flag is PC7 and the acknowledge is PC6; for group B the flag is PC1 and the acknowledge is PC2. A low acknowledge returns the flag high. The acknowledge returning high raises the interrupt request (PC3 or PC0) if the enable (PC6 for A, PC2 for B) is 1.
- R11: A port C read returns handshake outputs at their pin positions and the enable latch bit at the strobe or acknowledge position. Other pins follow their direction. In group A strobed input, PC7 and PC6 stay general-purpose, with output-enable pattern 8'hEF for mode word 8'hB0.
- R12: A group A mode field of 10 or 11 behaves as strobed mode (01).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_ni | input | 1 | Active-low select |
| rd_ni | input | 1 | Active-low read strobe |
| wr_ni | input | 1 | Active-low write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Host write data |
| rdata_o | output | 8 | Host read data |
| pa_i | input | 8 | Port A pin levels |
| pa_o | output | 8 | Port A drive values |
| pa_oe_o | output | 8 | Port A per-pin output-enable |
| pb_i | input | 8 | Port B pin levels |
| pb_o | output | 8 | Port B drive values |
| pb_oe_o | output | 8 | Port B per-pin output-enable |
| pc_i | input | 8 | Port C pin levels |
| pc_o | output | 8 | Port C drive values |
| pc_oe_o | output | 8 | Port C per-pin output-enable |

## Verification
The bench sweeps all sixteen direction combinations and all port C bit indices with both values. A design with a swapped direction field or a shifted set/reset index would drive the wrong pins or touch neighbouring bits. In the strobed modes it samples the interrupt request while the strobe is still low and again after it returns high. A design that raised the request on the falling edge, or ignored the enable bit, fails one of the two samples. It checks that the latched input byte survives a pin change, that a read clears buffer-full, and that a mode field of 10 takes the strobed pin assignment.

// File: rtl/ppi_pkg.sv
package ppi_pkg;
  localparam int PW = 8;
  localparam int AW = 2;
  localparam int NGRP = 2;
  localparam int IDXW = $clog2(PW);

  localparam logic [AW-1:0] ADDR_PA  = 2'd0;
  localparam logic [AW-1:0] ADDR_PB  = 2'd1;
  localparam logic [AW-1:0] ADDR_PC  = 2'd2;
  localparam logic [AW-1:0] ADDR_CTL = 2'd3;

  typedef struct packed {
    logic [1:0] a_mode;
    logic       a_in;
    logic       cu_in;
    logic       b_mode;
    logic       b_in;
    logic       cl_in;
  } mode_t;

  localparam mode_t MODE_RST = '{a_mode: 2'b00, a_in: 1'b1, cu_in: 1'b1,
                                 b_mode: 1'b0, b_in: 1'b1, cl_in: 1'b1};
endpackage

// File: rtl/ppi_hs_unit.sv
module ppi_hs_unit #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         strobed_i,
  input  logic         dir_in_i,
  input  logic [W-1:0] pins_i,
  input  logic         stb_ni,
  input  logic         ack_ni,
  input  logic         inte_i,
  input  logic         host_rd_i,
  input  logic         host_wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] out_q_o,
  output logic [W-1:0] in_q_o,
  output logic         ibf_o,
  output logic         obf_no,
  output logic         intr_o
);
  logic hs_line, hs_prev, hs_fall, hs_rise;
  logic ibf_q, obf_n_q, intr_q;
  logic [W-1:0] out_q, in_q;

  assign hs_line = dir_in_i ? stb_ni : ack_ni;
  assign hs_fall = hs_prev & ~hs_line;
  assign hs_rise = ~hs_prev & hs_line;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q   <= '0;
      in_q    <= '0;
      ibf_q   <= 1'b0;
      obf_n_q <= 1'b1;
      intr_q  <= 1'b0;
      hs_prev <= 1'b1;
    end else begin
      hs_prev <= hs_line;
      if (clr_i) begin
        out_q   <= '0;
        ibf_q   <= 1'b0;
        obf_n_q <= 1'b1;
        intr_q  <= 1'b0;
      end else begin
        if (host_wr_i) out_q <= wdata_i;
        if (strobed_i && dir_in_i) begin
          if (host_rd_i) begin
            ibf_q  <= 1'b0;
            intr_q <= 1'b0;
          end
          if (hs_fall) begin
            in_q  <= pins_i;
            ibf_q <= 1'b1;
          end
          if (hs_rise && ibf_q && inte_i) intr_q <= 1'b1;
        end else if (strobed_i) begin
          if (host_wr_i) begin
            obf_n_q <= 1'b0;
            intr_q  <= 1'b0;
          end
          if (hs_fall) obf_n_q <= 1'b1;
          if (hs_rise && obf_n_q && inte_i && !host_wr_i) intr_q <= 1'b1;
        end
      end
    end
  end

  assign out_q_o = out_q;
  assign in_q_o  = in_q;
  assign ibf_o   = ibf_q;
  assign obf_no  = obf_n_q;
  assign intr_o  = intr_q & inte_i;

  assert_ibf_on_strobe_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobed_i && dir_in_i && hs_fall && !clr_i |=> ibf_o);
  assert_ibf_source_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ibf_o) |-> $past(hs_fall));
  assert_read_clears_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobed_i && dir_in_i && host_rd_i && !hs_fall |=> !ibf_o && !intr_q);
  assert_obf_on_write_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobed_i && !dir_in_i && host_wr_i && !clr_i |=> !obf_no);
  assert_clear_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> obf_no && !ibf_o && !intr_q);
endmodule

// File: rtl/ppi_pc_map.sv
module ppi_pc_map (
  input  logic       a_strobed_i,
  input  logic       a_in_i,
  input  logic       cu_in_i,
  input  logic       b_strobed_i,
  input  logic       b_in_i,
  input  logic       cl_in_i,
  input  logic [7:0] pc_q_i,
  input  logic [7:0] pc_i,
  input  logic       ibf_a_i,
  input  logic       obf_a_ni,
  input  logic       intr_a_i,
  input  logic       ibf_b_i,
  input  logic       obf_b_ni,
  input  logic       intr_b_i,
  output logic [7:0] pc_o,
  output logic [7:0] pc_oe_o,
  output logic [7:0] pc_rd_o
);
  always_comb begin
    pc_o    = pc_q_i;
    pc_oe_o = {{4{~cu_in_i}}, {4{~cl_in_i}}};
    if (a_strobed_i) begin
      pc_oe_o[3] = 1'b1;
      pc_o[3]    = intr_a_i;
      if (a_in_i) begin
        pc_oe_o[5] = 1'b1;
        pc_o[5]    = ibf_a_i;
        pc_oe_o[4] = 1'b0;
      end else begin
        pc_oe_o[7] = 1'b1;
        pc_o[7]    = obf_a_ni;
        pc_oe_o[6] = 1'b0;
      end
    end
    if (b_strobed_i) begin
      pc_oe_o[0] = 1'b1;
      pc_o[0]    = intr_b_i;
      pc_oe_o[1] = 1'b1;
      pc_o[1]    = b_in_i ? ibf_b_i : obf_b_ni;
      pc_oe_o[2] = 1'b0;
    end
    for (int i = 0; i < 8; i++) pc_rd_o[i] = pc_oe_o[i] ? pc_o[i] : pc_i[i];
    // handshake input positions read back their enable latch bit
    if (a_strobed_i) begin
      if (a_in_i) pc_rd_o[4] = pc_q_i[4];
      else        pc_rd_o[6] = pc_q_i[6];
    end
    if (b_strobed_i) pc_rd_o[2] = pc_q_i[2];
  end
endmodule

// File: rtl/par_port_ctrl.sv
module par_port_ctrl
  import ppi_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_ni,
  input  logic          rd_ni,
  input  logic          wr_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [PW-1:0] wdata_i,
  output logic [PW-1:0] rdata_o,
  input  logic [PW-1:0] pa_i,
  output logic [PW-1:0] pa_o,
  output logic [PW-1:0] pa_oe_o,
  input  logic [PW-1:0] pb_i,
  output logic [PW-1:0] pb_o,
  output logic [PW-1:0] pb_oe_o,
  input  logic [PW-1:0] pc_i,
  output logic [PW-1:0] pc_o,
  output logic [PW-1:0] pc_oe_o
);
  mode_t         mode_q;
  logic [PW-1:0] pc_q, pc_rd;
  logic          wr_stb, rd_stb, mode_wr, bsr_wr, pc_wr;
  logic          a_strobed, b_strobed;

  logic [NGRP-1:0] g_strobed, g_in, g_stb_n, g_ack_n, g_inte, g_rd, g_wr;
  logic [NGRP-1:0] g_ibf, g_obf_n, g_intr;
  logic [PW-1:0]   g_pins [NGRP];
  logic [PW-1:0]   g_out  [NGRP];
  logic [PW-1:0]   g_inq  [NGRP];
  logic [PW-1:0]   g_rdv  [NGRP];

  assign wr_stb  = ~cs_ni & ~wr_ni;
  assign rd_stb  = ~cs_ni & ~rd_ni;
  assign mode_wr = wr_stb && addr_i == ADDR_CTL && wdata_i[7];
  assign bsr_wr  = wr_stb && addr_i == ADDR_CTL && !wdata_i[7];
  assign pc_wr   = wr_stb && addr_i == ADDR_PC;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_RST;
      pc_q   <= '0;
    end else begin
      if (mode_wr) begin
        mode_q <= mode_t'(wdata_i[6:0]);
        pc_q   <= '0;
      end else if (pc_wr) begin
        pc_q <= wdata_i;
      end else if (bsr_wr) begin
        pc_q[wdata_i[IDXW:1]] <= wdata_i[0];
      end
    end
  end

  assign a_strobed = |mode_q.a_mode;
  assign b_strobed = mode_q.b_mode;

  assign g_strobed = {b_strobed, a_strobed};
  assign g_in      = {mode_q.b_in, mode_q.a_in};
  assign g_stb_n   = {pc_i[2], pc_i[4]};
  assign g_ack_n   = {pc_i[2], pc_i[6]};
  assign g_inte    = {pc_q[2], mode_q.a_in ? pc_q[4] : pc_q[6]};
  assign g_rd      = {rd_stb && addr_i == ADDR_PB, rd_stb && addr_i == ADDR_PA};
  assign g_wr      = {wr_stb && addr_i == ADDR_PB, wr_stb && addr_i == ADDR_PA};
  assign g_pins[0] = pa_i;
  assign g_pins[1] = pb_i;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    ppi_hs_unit #(.W(PW)) u_hs (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .clr_i     (mode_wr),
      .strobed_i (g_strobed[g]),
      .dir_in_i  (g_in[g]),
      .pins_i    (g_pins[g]),
      .stb_ni    (g_stb_n[g]),
      .ack_ni    (g_ack_n[g]),
      .inte_i    (g_inte[g]),
      .host_rd_i (g_rd[g]),
      .host_wr_i (g_wr[g]),
      .wdata_i   (wdata_i),
      .out_q_o   (g_out[g]),
      .in_q_o    (g_inq[g]),
      .ibf_o     (g_ibf[g]),
      .obf_no    (g_obf_n[g]),
      .intr_o    (g_intr[g])
    );
    assign g_rdv[g] = !g_in[g]    ? g_out[g] :
                      g_strobed[g] ? g_inq[g] : g_pins[g];
  end

  ppi_pc_map u_pc_map (
    .a_strobed_i (a_strobed),
    .a_in_i      (mode_q.a_in),
    .cu_in_i     (mode_q.cu_in),
    .b_strobed_i (b_strobed),
    .b_in_i      (mode_q.b_in),
    .cl_in_i     (mode_q.cl_in),
    .pc_q_i      (pc_q),
    .pc_i        (pc_i),
    .ibf_a_i     (g_ibf[0]),
    .obf_a_ni    (g_obf_n[0]),
    .intr_a_i    (g_intr[0]),
    .ibf_b_i     (g_ibf[1]),
    .obf_b_ni    (g_obf_n[1]),
    .intr_b_i    (g_intr[1]),
    .pc_o        (pc_o),
    .pc_oe_o     (pc_oe_o),
    .pc_rd_o     (pc_rd)
  );

  assign pa_o    = g_out[0];
  assign pb_o    = g_out[1];
  assign pa_oe_o = {PW{~mode_q.a_in}};
  assign pb_oe_o = {PW{~mode_q.b_in}};

  always_comb begin
    rdata_o = '0;
    if (rd_stb) begin
      unique case (addr_i)
        ADDR_PA: rdata_o = g_rdv[0];
        ADDR_PB: rdata_o = g_rdv[1];
        ADDR_PC: rdata_o = pc_rd;
        default: rdata_o = '0;
      endcase
    end
  end

  assert_bsr_single_bit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bsr_wr |=> ((pc_q ^ $past(pc_q)) & ~(PW'(1) << $past(wdata_i[IDXW:1]))) == '0);
  assert_mode_clears_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_wr |=> pa_o == '0 && pb_o == '0 && pc_q == '0);
  assert_deselect_holds_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> $stable(mode_q) && $stable(pc_q));
endmodule

// File: tb/tb_par_port_ctrl.sv
`timescale 1ns/1ps
module tb_par_port_ctrl;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cs_ni = 1'b1, rd_ni = 1'b1, wr_ni = 1'b1;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [7:0] pa_i = '0, pb_i = '0, pc_i = 8'hFF;
  logic [7:0] pa_o, pa_oe, pb_o, pb_oe, pc_o, pc_oe;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  par_port_ctrl dut (
    .clk_i(clk), .rst_ni(rst_ni), .cs_ni(cs_ni), .rd_ni(rd_ni), .wr_ni(wr_ni),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .pa_i(pa_i), .pa_o(pa_o), .pa_oe_o(pa_oe),
    .pb_i(pb_i), .pb_o(pb_o), .pb_oe_o(pb_oe),
    .pc_i(pc_i), .pc_o(pc_o), .pc_oe_o(pc_oe));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d, input bit sel = 1'b1);
    @(negedge clk);
    cs_ni = ~sel; wr_ni = 1'b0; addr = a; wdata = d;
    @(negedge clk);
    cs_ni = 1'b1; wr_ni = 1'b1;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d, input bit sel = 1'b1);
    @(negedge clk);
    cs_ni = ~sel; rd_ni = 1'b0; addr = a;
    #1 d = rdata;
    @(negedge clk);
    cs_ni = 1'b1; rd_ni = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] r, exp;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R2 reset state
    chk("R2 pa_oe", pa_oe, 8'h00);
    chk("R2 pb_oe", pb_oe, 8'h00);
    chk("R2 pc_oe", pc_oe, 8'h00);
    pa_i = 8'h5A;
    rd(2'd0, r);
    chk("R2 port A reads pins", r, 8'h5A);
    rd(2'd3, r);
    chk("R1 control reads zero", r, 8'h00);

    // R3 R5 R6 direction sweep
    for (int d = 0; d < 16; d++) begin
      logic [7:0] w, va, vb, vc;
      w = 8'h80 | (8'(d >> 3 & 1) << 4) | (8'(d >> 2 & 1) << 3)
                | (8'(d >> 1 & 1) << 1) | 8'(d & 1);
      wr(2'd0, 8'hFF);
      wr(2'd3, w);
      chk("R5 port A latch cleared", pa_o, 8'h00);
      chk("R3 pa_oe", pa_oe, d[3] ? 8'h00 : 8'hFF);
      chk("R3 pb_oe", pb_oe, d[1] ? 8'h00 : 8'hFF);
      chk("R3 pc_oe", pc_oe, {d[2] ? 4'h0 : 4'hF, d[0] ? 4'h0 : 4'hF});
      va = 8'h30 + 8'(d); vb = 8'h90 + 8'(d); vc = 8'h50 + 8'(d);
      pa_i = 8'hA0 ^ 8'(d); pb_i = 8'h0C ^ 8'(d); pc_i = 8'hFF;
      wr(2'd0, va); wr(2'd1, vb); wr(2'd2, vc);
      chk("R6 pa_o latch", pa_o, va);
      rd(2'd0, r); chk("R6 port A read", r, d[3] ? pa_i : va);
      rd(2'd1, r); chk("R6 port B read", r, d[1] ? pb_i : vb);
      rd(2'd2, r); chk("R6 port C read", r, {d[2] ? 4'hF : vc[7:4], d[0] ? 4'hF : vc[3:0]});
    end

    // R1 chip select
    wr(2'd3, 8'h80);
    wr(2'd0, 8'h11);
    wr(2'd0, 8'hEE, 1'b0);
    chk("R1 write ignored without select", pa_o, 8'h11);
    rd(2'd0, r, 1'b0);
    chk("R1 rdata zero without select", r, 8'h00);
    wr(2'd3, 8'h9B, 1'b0);
    chk("R1 control ignored without select", pa_oe, 8'hFF);

    // R4 bit set/reset sweep
    wr(2'd2, 8'h00);
    exp = 8'h00;
    for (int i = 0; i < 8; i++) begin
      wr(2'd3, 8'(i << 1) | 8'h01);
      exp = exp | 8'(1 << i);
      chk("R4 set bit", pc_o, exp);
    end
    for (int i = 7; i >= 0; i--) begin
      wr(2'd3, 8'(i << 1));
      exp = exp & ~8'(1 << i);
      chk("R4 clear bit", pc_o, exp);
    end
    wr(2'd2, 8'hA5);
    wr(2'd3, 8'h06);
    chk("R4 clear bit 3 only", pc_o, 8'hA5 & ~8'h08);
    wr(2'd3, 8'h80);
    chk("R5 port C latch cleared", pc_o, 8'h00);

    // group A strobed input: R7 R8 R9 R11
    pc_i = 8'hFF;
    wr(2'd3, 8'hB0);
    chk("R11 pc_oe strobed input A", pc_oe, 8'hEF);
    chk("R7 pa_oe input", pa_oe, 8'h00);
    pa_i = 8'h3C;
    @(negedge clk); pc_i[4] = 1'b0;
    @(negedge clk); pc_i[4] = 1'b1;
    @(negedge clk);
    chk("R7 IBF on PC5", {7'd0, pc_o[5]}, 8'h01);
    chk("R8 no INTR without enable", {7'd0, pc_o[3]}, 8'h00);
    pa_i = 8'h00;
    rd(2'd0, r);
    chk("R7 latched byte held", r, 8'h3C);
    chk("R9 IBF cleared by read", {7'd0, pc_o[5]}, 8'h00);
    wr(2'd3, 8'h09);
    pa_i = 8'hC3;
    @(negedge clk); pc_i[4] = 1'b0;
    @(negedge clk);
    chk("R7 IBF while strobe low", {7'd0, pc_o[5]}, 8'h01);
    chk("R8 INTR waits for strobe high", {7'd0, pc_o[3]}, 8'h00);
    pc_i[4] = 1'b1;
    @(negedge clk);
    chk("R8 INTR on PC3", {7'd0, pc_o[3]}, 8'h01);
    rd(2'd2, r);
    chk("R11 port C status read", r, 8'h38);
    wr(2'd3, 8'h0F);
    chk("R11 PC7 general purpose", {7'd0, pc_o[7]}, 8'h01);
    rd(2'd0, r);
    chk("R7 second byte", r, 8'hC3);
    chk("R9 INTR cleared by read", {7'd0, pc_o[3]}, 8'h00);
    chk("R9 IBF cleared", {7'd0, pc_o[5]}, 8'h00);

    // R12 mode field 10
    wr(2'd3, 8'hD0);
    chk("R12 mode 10 as strobed", pc_oe, 8'hEF);

    // group B strobed output: R10
    wr(2'd3, 8'h84);
    chk("R10 pc_oe strobed output B", pc_oe, 8'hFB);
    chk("R10 OBF idle high", {7'd0, pc_o[1]}, 8'h01);
    wr(2'd3, 8'h05);
    wr(2'd1, 8'h77);
    chk("R10 pb_o data", pb_o, 8'h77);
    chk("R10 OBF low after write", {7'd0, pc_o[1]}, 8'h00);
    @(negedge clk); pc_i[2] = 1'b0;
    @(negedge clk);
    chk("R10 OBF high on ack", {7'd0, pc_o[1]}, 8'h01);
    chk("R10 INTR waits ack high", {7'd0, pc_o[0]}, 8'h00);
    pc_i[2] = 1'b1;
    @(negedge clk);
    chk("R10 INTR on PC0", {7'd0, pc_o[0]}, 8'h01);
    rd(2'd2, r);
    chk("R11 port C status B", r, 8'h07);
    wr(2'd1, 8'h12);
    chk("R10 write clears INTR", {7'd0, pc_o[0]}, 8'h00);
    wr(2'd3, 8'h04);
    @(negedge clk); pc_i[2] = 1'b0;
    @(negedge clk); pc_i[2] = 1'b1;
    @(negedge clk);
    chk("R10 OBF high no enable", {7'd0, pc_o[1]}, 8'h01);
    chk("R10 no INTR without enable", {7'd0, pc_o[0]}, 8'h00);

    // group A strobed output: R10
    wr(2'd3, 8'hA0);
    chk("R10 pc_oe strobed output A", pc_oe, 8'hBF);
    wr(2'd0, 8'h99);
    chk("R10 PC7 OBF low", {7'd0, pc_o[7]}, 8'h00);
    wr(2'd3, 8'h0D);
    @(negedge clk); pc_i[6] = 1'b0;
    @(negedge clk); pc_i[6] = 1'b1;
    @(negedge clk);
    chk("R10 PC7 OBF high", {7'd0, pc_o[7]}, 8'h01);
    chk("R10 PC3 INTR A", {7'd0, pc_o[3]}, 8'h01);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule